// File: doc/BRIEF.md
# Error Record Bank Register Front End

This block is the memory-mapped register face of one bank of error records. A requester issues aligned 4-byte or 8-byte reads and writes, given as byte offsets within the bank, on a simple request/response bus. The first 64 bytes of the bank are a header. It carries an identification word, a bank description word and a summary of which records currently hold a valid error. A run of 64-byte record windows follows the header, one window for each of `N_REC` records.

Inside each record only the control and status words hold state. The address, information, supplemental and timestamp words are hardwired to zero. The control word has two write-one command bits. One sets the record's read-in-progress flag. The other drops the valid bit, but only when read-in-progress is already set. This lets a handler read a record and then retire it without losing sight of an overwrite that happened while it was reading.

An 8-byte access is carried out as two 32-bit half operations on consecutive cycles, low half first. Every other offset reads as zero and ignores writes.

Top module: `errBankRegs`

## Requirements
- R1: The word at offset 0 reads `{IMP_ID, VENDOR_ID}`, with the vendor value in bits 31:0. Writes to it change nothing.
- R2: The word at offset 8 reads `INST_ID` in bits 15:0, `N_REC` in bits 21:16, layout 0 in bits 23:22 and version 0x01 in bits 63:56. All other bits read zero.
- R3: The word at offset 16 reads 1 in bit 0. Bit i+1 equals the valid bit (status bit 0) of record i, and all higher bits read zero. Writes to it change nothing.
- R4: These offsets read zero and discard writes: header offsets 24 to 63, record offsets +16 to +63, and everything past the last record.
- R5: The control word of record i sits at 64+64·i. Bits 7:0 are read/write and hold, from the LSB up: log enable, count enable, and three 2-bit signal selects. All other bits read zero.
- R6: The status word of record i sits at 64+64·i+8. While its valid bit 0 is clear, a write stores the data masked to the implemented fields: low half mask 0xFFB3FFFF, high half mask 0xFFFF0000.
- R7: A status write has no effect while that record's valid bit is 1.
- R8: A write of 1 to control bit 49 sets status bit 23 (read-in-progress). A write of 1 to control bit 48 clears the valid bit if bit 23 is set or is being set in the same write. Both command bits read 0.
- R9: For a 4-byte access, address bit 2 selects the half. The write data is taken from `reqWdata[31:0]` and the read data is returned in `rspRdata[31:0]`, with bits 63:32 zero. The response arrives one cycle after acceptance and `reqReady` stays high.
- R10: An 8-byte access is little-endian: the low half (bits 31:0) is handled first and the high half on the next cycle. `reqReady` is low for that one cycle, and the response carries all 64 bits two cycles after acceptance.
- R11: After reset, every control and status word is zero, `rspValid` is 0 and `reqReady` is 1.
- R12: Write responses return all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reqAddr | input | ADDR_W | Byte offset within the bank |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | One-cycle response pulse |
| rspRdata | output | 64 | Read data |

## Verification
The assertions check the following on every cycle: a locked status word does not move, the two command bits take effect on the following cycle, and the split-access sequencing holds, with the high half following the low half and the response coming one cycle later. The summary bit 0 is also checked on each read of that word. The exact header values, the field masks, the zero read-back of reserved and out-of-range windows, and the little-endian placement of each half only show up as values at the ports. Those are covered by the bench's scenarios. The same holds for the ordering cases: invalidate without read-in-progress, invalidate after it, and both command bits together.

// File: rtl/errBankPkg.sv
package errBankPkg;
  typedef enum logic {ST_IDLE, ST_HI} seqState_t;

  typedef struct packed {
    logic act;        // a half operation happens this cycle
    logic wr;         // it is a write
    logic hiHalf;     // operates on bits 63:32 of the target word
    logic upperLane;  // result goes to rspRdata[63:32]
    logic finish;     // last half of the access
  } halfOp_t;

  localparam logic [31:0] STAT_LO_MASK = 32'hFFB3_FFFF;
  localparam logic [31:0] STAT_HI_MASK = 32'hFFFF_0000;
endpackage

// File: rtl/errBankCtrl.sv
module errBankCtrl
  import errBankPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqWdata,
  output halfOp_t           op,
  output logic [ADDR_W-4:0] opWord,
  output logic [31:0]       opData,
  output logic              rspValid
);
  localparam int WI = ADDR_W - 3;

  seqState_t        state;
  logic             wrQ;
  logic [WI-1:0]    wordQ;
  logic [31:0]      hiDataQ;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    if (state == ST_IDLE) begin
      op.act       = reqValid;
      op.wr        = reqWrite;
      op.hiHalf    = reqWide ? 1'b0 : reqAddr[2];
      op.upperLane = 1'b0;
      op.finish    = !reqWide;
      opWord       = reqAddr[ADDR_W-1:3];
      opData       = reqWdata[31:0];
    end else begin
      op.act       = 1'b1;
      op.wr        = wrQ;
      op.hiHalf    = 1'b1;
      op.upperLane = 1'b1;
      op.finish    = 1'b1;
      opWord       = wordQ;
      opData       = hiDataQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
      wrQ      <= 1'b0;
      wordQ    <= '0;
      hiDataQ  <= '0;
    end else begin
      rspValid <= op.act && op.finish;
      if (state == ST_IDLE && reqValid && reqWide) begin
        state   <= ST_HI;
        wrQ     <= reqWrite;
        wordQ   <= reqAddr[ADDR_W-1:3];
        hiDataQ <= reqWdata[63:32];
      end else begin
        state <= ST_IDLE;
      end
    end
  end

  a_r10_high_follows: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && reqWide) |=> (state == ST_HI && !reqReady));
  a_r10_rsp_after_high: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HI) |=> rspValid);
  a_r9_single_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && !reqWide) |=> (rspValid && reqReady));
endmodule

// File: rtl/errRecord.sv
module errRecord
  import errBankPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrLo,
  input  logic        ctrlWrHi,
  input  logic        statWrLo,
  input  logic        statWrHi,
  input  logic [31:0] wd,
  output logic [63:0] ctrlRd,
  output logic [63:0] statRd,
  output logic        valid
);
  logic [7:0]  ctrlQ;
  logic [63:0] statQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      statQ <= '0;
    end else begin
      if (ctrlWrLo) ctrlQ <= wd[7:0];
      if (statWrLo && !statQ[0]) statQ[31:0]  <= wd & STAT_LO_MASK;
      if (statWrHi && !statQ[0]) statQ[63:32] <= wd & STAT_HI_MASK;
      if (ctrlWrHi) begin
        if (wd[17]) statQ[23] <= 1'b1;
        if (wd[16] && (wd[17] || statQ[23])) statQ[0] <= 1'b0;
      end
    end
  end

  assign ctrlRd = {56'd0, ctrlQ};
  assign statRd = statQ;
  assign valid  = statQ[0];

  a_r7_status_locked: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[0] && (statWrLo || statWrHi) && !ctrlWrHi) |=> $stable(statQ));
  a_r8_invalidate: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrHi && wd[16] && statQ[23]) |=> !statQ[0]);
  a_r8_set_rdip: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrHi && wd[17]) |=> statQ[23]);
endmodule

// File: rtl/errBankData.sv
module errBankData
  import errBankPkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          N_REC     = 4,
  parameter logic [31:0] VENDOR_ID = 32'h0,
  parameter logic [31:0] IMP_ID    = 32'h0,
  parameter logic [15:0] INST_ID   = 16'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  halfOp_t           op,
  input  logic [ADDR_W-4:0] opWord,
  input  logic [31:0]       opData,
  output logic [63:0]       rspRdata
);
  localparam int WI = ADDR_W - 3;
  localparam int BW = WI - 3;

  logic [2:0]    regSel;
  logic [BW-1:0] blk;
  logic [BW-1:0] recIdx;
  logic          isHdr;
  logic          recHit;
  logic [63:0]   ctrlRd [N_REC];
  logic [63:0]   statRd [N_REC];
  logic [N_REC-1:0] validVec;
  logic [63:0]   idWord, infoWord, sumWord, rd64;
  logic [31:0]   halfVal;

  assign regSel = opWord[2:0];
  assign blk    = opWord[WI-1:3];
  assign isHdr  = (blk == '0);
  assign recIdx = blk - BW'(1);
  assign recHit = !isHdr && (blk <= BW'(N_REC));

  for (genvar i = 0; i < N_REC; i++) begin : g_rec
    logic hit;
    assign hit = op.act && op.wr && recHit && (recIdx == BW'(i));
    errRecord u_rec (
      .clk      (clk),
      .rstN     (rstN),
      .ctrlWrLo (hit && regSel == 3'd0 && !op.hiHalf),
      .ctrlWrHi (hit && regSel == 3'd0 &&  op.hiHalf),
      .statWrLo (hit && regSel == 3'd1 && !op.hiHalf),
      .statWrHi (hit && regSel == 3'd1 &&  op.hiHalf),
      .wd       (opData),
      .ctrlRd   (ctrlRd[i]),
      .statRd   (statRd[i]),
      .valid    (validVec[i])
    );
  end

  assign idWord   = {IMP_ID, VENDOR_ID};
  assign infoWord = {8'h01, 32'd0, 2'b00, 6'(N_REC), INST_ID};

  always_comb begin
    sumWord = 64'd1;
    for (int i = 0; i < N_REC; i++) sumWord[i+1] = validVec[i];
  end

  always_comb begin
    rd64 = '0;
    if (isHdr) begin
      case (regSel)
        3'd0:    rd64 = idWord;
        3'd1:    rd64 = infoWord;
        3'd2:    rd64 = sumWord;
        default: rd64 = '0;
      endcase
    end else if (recHit) begin
      for (int i = 0; i < N_REC; i++) begin
        if (recIdx == BW'(i)) begin
          if (regSel == 3'd0)      rd64 = ctrlRd[i];
          else if (regSel == 3'd1) rd64 = statRd[i];
        end
      end
    end
  end

  assign halfVal = op.wr ? 32'd0 : (op.hiHalf ? rd64[63:32] : rd64[31:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspRdata <= '0;
    end else if (op.act) begin
      if (op.upperLane) rspRdata[63:32] <= halfVal;
      else              rspRdata        <= {32'd0, halfVal};
    end
  end

  a_r3_sv_set: assert property (@(posedge clk) disable iff (!rstN)
    (op.act && !op.wr && isHdr && regSel == 3'd2 && !op.hiHalf && !op.upperLane)
      |=> rspRdata[0]);
endmodule

// File: rtl/errBankRegs.sv
module errBankRegs
  import errBankPkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          N_REC     = 4,
  parameter logic [31:0] VENDOR_ID = 32'h1234_5678,
  parameter logic [31:0] IMP_ID    = 32'h0000_0A01,
  parameter logic [15:0] INST_ID   = 16'h0042
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqWdata,
  output logic              rspValid,
  output logic [63:0]       rspRdata
);
  halfOp_t           op;
  logic [ADDR_W-4:0] opWord;
  logic [31:0]       opData;

  initial begin
    assert (N_REC >= 1 && N_REC <= 63) else $error("N_REC out of range");
    assert ((1 << ADDR_W) >= 64 * (N_REC + 1)) else $error("ADDR_W too small");
  end

  errBankCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqWrite (reqWrite),
    .reqWide  (reqWide),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .op       (op),
    .opWord   (opWord),
    .opData   (opData),
    .rspValid (rspValid)
  );

  errBankData #(
    .ADDR_W(ADDR_W), .N_REC(N_REC), .VENDOR_ID(VENDOR_ID),
    .IMP_ID(IMP_ID), .INST_ID(INST_ID)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .op       (op),
    .opWord   (opWord),
    .opData   (opData),
    .rspRdata (rspRdata)
  );
endmodule

// File: tb/errBankRegs_tb.sv
module errBankRegs_tb;
  localparam logic [31:0] VID  = 32'h1234_5678;
  localparam logic [31:0] IID  = 32'h0000_0A01;
  localparam logic [15:0] INST = 16'h0042;
  localparam int          NREC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic        reqReady, rspValid;
  logic [63:0] rspRdata;
  int          nChk = 0, nBad = 0, cyc = 0;
  logic [63:0] r;

  always #10 clk = ~clk;

  errBankRegs u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: run hung, act=%0d exp<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // returns response data and cycles from acceptance to response
  task automatic access(input logic wr, input logic wide, input logic [11:0] a,
                        input logic [63:0] d, output logic [63:0] rd, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWide = wide; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid) begin @(negedge clk); lat++; end
    rd = rspRdata;
  endtask

  task automatic rd8(input logic [11:0] a, output logic [63:0] rd);
    int l; access(1'b0, 1'b1, a, 64'd0, rd, l);
  endtask
  task automatic wr8(input logic [11:0] a, input logic [63:0] d);
    int l; logic [63:0] x; access(1'b1, 1'b1, a, d, x, l);
  endtask
  task automatic wr4(input logic [11:0] a, input logic [31:0] d);
    int l; logic [63:0] x; access(1'b1, 1'b0, a, {32'hDEAD_BEEF, d}, x, l);
  endtask

  task automatic t_reset();
    check("R11 rspValid", {63'd0, rspValid}, 64'd0);
    check("R11 reqReady", {63'd0, reqReady}, 64'd1);
    rd8(12'd72, r);  check("R11 rec0 status", r, 64'd0);
    rd8(12'd192, r); check("R11 rec2 control", r, 64'd0);
  endtask

  task automatic t_header();
    rd8(12'd0, r);  check("R1 id word", r, {IID, VID});
    wr8(12'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd8(12'd0, r);  check("R1 id write ignored", r, {IID, VID});
    rd8(12'd8, r);  check("R2 bank info", r, {8'h01, 32'd0, 2'b00, 6'(NREC), INST});
    rd8(12'd16, r); check("R3 summary idle", r, 64'd1);
  endtask

  task automatic t_narrow();
    int l; logic [63:0] x;
    access(1'b0, 1'b0, 12'd8, 64'd0, x, l);
    check("R9 low half", x, {32'd0, 16'(NREC), INST});
    check("R9 latency", 64'(l), 64'd1);
    access(1'b0, 1'b0, 12'd12, 64'd0, x, l);
    check("R9 high half", x, 64'h0000_0000_0100_0000);
    access(1'b0, 1'b0, 12'd4, 64'd0, x, l);
    check("R9 id high half", x, {32'd0, IID});
    access(1'b1, 1'b0, 12'd64, 64'd0, x, l);
    check("R12 write rsp zero", x, 64'd0);
  endtask

  task automatic t_wide();
    int l; logic [63:0] x;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqWide = 1'b1; reqAddr = 12'd0;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 ready low", {63'd0, reqReady}, 64'd0);
    check("R10 no early rsp", {63'd0, rspValid}, 64'd0);
    @(negedge clk);
    check("R10 rsp at 2", {63'd0, rspValid}, 64'd1);
    check("R10 full word", rspRdata, {IID, VID});
    access(1'b0, 1'b1, 12'd8, 64'd0, x, l);
    check("R10 latency", 64'(l), 64'd2);
  endtask

  task automatic t_control();
    wr8(12'd64, 64'hFFFF_FFFF_FFFF_FFFF);
    rd8(12'd64, r); check("R5 ctrl fields", r, 64'h0000_0000_0000_00FF);
    wr4(12'd128, 32'h0000_00A5);
    rd8(12'd128, r); check("R5 rec1 ctrl 4B", r, 64'h0000_0000_0000_00A5);
    rd8(12'd64, r);  check("R5 rec0 untouched", r, 64'h0000_0000_0000_00FF);
  endtask

  task automatic t_status();
    wr8(12'd72, 64'hFFFF_FFFF_FFFF_FFFE);
    rd8(12'd72, r); check("R6 masked write", r, 64'hFFFF_0000_FFB3_FFFE);
    wr4(12'd72, 32'h0000_0001);
    rd8(12'd72, r); check("R6 set valid", r, 64'hFFFF_0000_0000_0001);
    rd8(12'd16, r); check("R3 summary rec0", r, 64'd3);
    wr8(12'd72, 64'h0000_0000_FFFF_FFFE);
    rd8(12'd72, r); check("R7 locked status", r, 64'hFFFF_0000_0000_0001);
  endtask

  task automatic t_commands();
    wr4(12'd68, 32'h0001_0000);          // invalidate, rdip clear
    rd8(12'd72, r); check("R8 no rdip keeps valid", r, 64'hFFFF_0000_0000_0001);
    wr4(12'd68, 32'h0002_0000);          // set rdip
    rd8(12'd72, r); check("R8 rdip set", r, 64'hFFFF_0000_0080_0001);
    rd8(12'd64, r); check("R8 cmd bits read 0", r, 64'h0000_0000_0000_00FF);
    wr4(12'd68, 32'h0001_0000);          // invalidate
    rd8(12'd72, r); check("R8 invalidated", r, 64'hFFFF_0000_0080_0000);
    wr4(12'd200, 32'h0000_0001);         // record 2 valid
    wr4(12'd256+12'd8, 32'h0000_0001);   // record 3 valid
    rd8(12'd16, r); check("R3 summary rec2 rec3", r, 64'h19);
    wr4(12'd196, 32'h0003_0000);         // both commands together
    rd8(12'd200, r); check("R8 both bits", r, 64'h0000_0000_0080_0000);
    rd8(12'd16, r); check("R3 summary rec3 only", r, 64'h11);
  endtask

  task automatic t_reserved();
    wr8(12'd24, 64'hFFFF_FFFF_FFFF_FFFF);
    rd8(12'd24, r); check("R4 header reserved", r, 64'd0);
    rd8(12'd56, r); check("R4 header custom", r, 64'd0);
    wr8(12'd80, 64'hFFFF_FFFF_FFFF_FFFF);
    rd8(12'd80, r); check("R4 record addr word", r, 64'd0);
    wr8(12'd320, 64'hFFFF_FFFF_FFFF_FFFF);
    rd8(12'd320, r); check("R4 past last record", r, 64'd0);
    wr8(12'd16, 64'h0);
    rd8(12'd16, r); check("R3 summary write ignored", r, 64'h11);
    rd8(12'd64, r); check("R4 rec0 ctrl kept", r, 64'h0000_0000_0000_00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_header();
    t_narrow();
    t_wide();
    t_control();
    t_status();
    t_commands();
    t_reserved();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule